// File: doc/BRIEF.md
# Power-Guarded Byte-Wide Static Memory

This block is a byte-wide static memory with an address bus, a bidirectional data bus and three active-low strobes: select, write and output enable. A free-running sampling clock captures every pin. The block decodes read and write cycles from the sampled strobes and drives the shared data bus only while a read is in progress. A write opens when both select and write strobe are low and closes when either of them goes high. The byte on the bus just before the closing edge is stored at the address held when the write opened.

A power-good input gates every access. While it is low, the strobes, address and data are ignored, the bus floats, and any write still open is dropped without storing. The array has no reset, so its contents survive power-good drops and resets. An address change while a write is open raises a protocol-error flag. The flag stays set until the next write opens. The address width is a parameter: 15 bits gives the full 32,768-byte array, and a smaller default keeps elaboration light.

Top module: `guarded_sram`

## Requirements
- R1: With power good, select low, output enable low and write strobe high, the data bus carries the byte stored at the address no later than the second sampling edge after the pins settle.
- R2: A write opened and closed by the write strobe while select stays low stores the bus byte at the addressed location.
- R3: A write opens at whichever of select or write strobe falls later. A write where the write strobe is low first and select falls afterwards also stores its byte.
- R4: A write closes at whichever of select or write strobe rises first. The stored byte is the bus value in the last sampled cycle before that rise, so earlier bus values during the same write are overwritten.
- R5: While the write strobe is low the block does not drive the bus, even with select and output enable low.
- R6: While power-good is low the bus floats, and write attempts leave the array unchanged.
- R7: Array contents persist across power-good deassertion and across assertion of the active-low reset.
- R8: An address change while a write is open sets the error output to 1. The error output stays at 1 until the next write opens. The byte goes to the address sampled when the write opened.
- R9: The bus floats whenever select is high or output enable is high. After reset, the error output is 0 and the bus floats.
- R10: A write that is still open when power-good falls is discarded and stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_good | input | 1 | Supply in tolerance when high |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| dq | inout | DATA_W | Bidirectional data bus |
| addr_err | output | 1 | Address moved during an open write |

## Verification
Writes are run in two forms: ended by the write strobe with select held low, and ended by select with the write strobe lowered first. Together they separate the later-falling-edge start from the earlier-rising-edge end. A write whose bus value changes midway shows whether the last value or the first one is stored. Reads are tried with each enable held inactive in turn, and once with the write strobe low, which shows that the write strobe suppresses the output driver. Writes are also attempted with power-good low, and a write is interrupted by a power-good drop; read-back after power returns separates a blocked or aborted write from a stored one. A stored byte is read back after a reset pulse, and one write moves its address midway, which checks both the error flag and the address the byte lands at.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  // Sampled strobes, converted to active-high and already gated by power-good.
  typedef struct packed {
    logic pwr;
    logic sel;
    logic wr;
    logic rd;
  } ctl_t;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_OPEN = 1'b1
  } wstate_e;

endpackage

// File: rtl/gsr_sample.sv
module gsr_sample
  import gsr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_data
);

  ctl_t              ctl_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  // Power-good masks every strobe; address and data hold while power is bad.
  always_comb begin
    ctl_d.pwr = pwr_good;
    ctl_d.sel = pwr_good & ~sel_n;
    ctl_d.wr  = pwr_good & ~wr_n;
    ctl_d.rd  = pwr_good & ~rd_en_n;
    addr_d    = pwr_good ? addr : s_addr;
    data_d    = pwr_good ? din  : s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      s_addr <= '0;
      s_data <= '0;
    end else begin
      ctl    <= ctl_d;
      s_addr <= addr_d;
      s_data <= data_d;
    end
  end

endmodule

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              drive,
  output logic              addr_err,
  output logic              wr_open
);

  wstate_e           st_q, st_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              err_d, drv_d;
  logic              wr_on, start, finish;

  assign wr_on  = ctl.sel & ctl.wr;
  assign start  = (st_q == WS_IDLE) & wr_on;
  assign finish = (st_q == WS_OPEN) & ~wr_on & ctl.pwr;

  always_comb begin
    st_d  = st_q;
    wa_d  = wa_q;
    wd_d  = wd_q;
    err_d = addr_err;
    if (wr_on) wd_d = s_data;
    if (start) begin
      st_d  = WS_OPEN;
      wa_d  = s_addr;
      err_d = 1'b0;
    end else if (st_q == WS_OPEN) begin
      if (!wr_on) st_d = WS_IDLE;
      else if (s_addr != wa_q) err_d = 1'b1;
    end
    drv_d = ctl.sel & ctl.rd & ~ctl.wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WS_IDLE;
      wa_q     <= '0;
      wd_q     <= '0;
      addr_err <= 1'b0;
      drive    <= 1'b0;
    end else begin
      st_q     <= st_d;
      wa_q     <= wa_d;
      wd_q     <= wd_d;
      addr_err <= err_d;
      drive    <= drv_d;
    end
  end

  assign mem_we    = finish;
  assign mem_waddr = wa_q;
  assign mem_wdata = wd_q;
  assign wr_open   = (st_q == WS_OPEN);

  AST_ERR_RISES_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err) |-> $past(st_q == WS_OPEN)); // R8

endmodule

// File: rtl/gsr_array.sv
module gsr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // No reset: contents survive power-good drops and resets.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/guarded_sram.sv
module guarded_sram
  import gsr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dq,
  output logic              addr_err
);

  logic [1:0]        rst_pipe;
  logic              rst_s;
  ctl_t              ctl;
  logic [ADDR_W-1:0] s_addr, mem_waddr;
  logic [DATA_W-1:0] s_data, mem_wdata, rdata;
  logic              mem_we, drive, wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  gsr_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
    .clk(clk), .rst_n(rst_s), .pwr_good(pwr_good), .sel_n(sel_n),
    .wr_n(wr_n), .rd_en_n(rd_en_n), .addr(addr), .din(dq),
    .ctl(ctl), .s_addr(s_addr), .s_data(s_data)
  );

  gsr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .ctl(ctl), .s_addr(s_addr), .s_data(s_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .drive(drive), .addr_err(addr_err), .wr_open(wr_open)
  );

  gsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(s_addr), .rdata(rdata)
  );

  assign dq = drive ? rdata : {DATA_W{1'bz}};

  AST_COMMIT_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> $past(wr_open)); // R4
  AST_COMMIT_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> $past(ctl.pwr)); // R10
  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_s)
    drive |-> !$past(ctl.wr)); // R5
  AST_FLOAT_ON_POWER_BAD: assert property (@(posedge clk) disable iff (!rst_s)
    !ctl.pwr |=> !drive); // R6
  AST_FLOAT_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_s)
    !ctl.sel |=> !drive); // R9

endmodule

// File: tb/guarded_sram_test.sv
`timescale 1ns/1ps
module guarded_sram_test;

  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good = 1'b0;
  logic          sel_n = 1'b1, wr_n = 1'b1, rd_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] tb_val = '0;
  logic          tb_en = 1'b0;
  wire  [DW-1:0] dq;
  logic          addr_err;
  int            n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign dq = tb_en ? tb_val : {DW{1'bz}};
  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (dq[i]);
  end

  guarded_sram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
    .wr_n(wr_n), .rd_en_n(rd_en_n), .addr(addr), .dq(dq), .addr_err(addr_err)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ce_ctl=0: select low first, write strobe pulses. ce_ctl=1: write strobe low first, select pulses.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_ctl);
    @(negedge clk);
    addr = a; tb_val = d; tb_en = 1'b1; rd_en_n = 1'b1;
    if (ce_ctl) wr_n = 1'b0; else sel_n = 1'b0;
    idle(2);
    if (ce_ctl) sel_n = 1'b0; else wr_n = 1'b0;
    idle(3);
    if (ce_ctl) sel_n = 1'b1; else wr_n = 1'b1;
    idle(2);
    sel_n = 1'b1; wr_n = 1'b1; tb_en = 1'b0;
    idle(2);
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] got);
    @(negedge clk);
    addr = a; sel_n = 1'b0; rd_en_n = 1'b0; wr_n = 1'b1;
    idle(3);
    got = dq;
    sel_n = 1'b1; rd_en_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset();
    idle(4);
    check("R9 reset bus floats", dq, 8'hFF);
    check("R9 reset error clear", {7'd0, addr_err}, 8'h00);
  endtask

  task automatic t_basic();
    logic [DW-1:0] g;
    do_write(11'h010, 8'h3C, 1'b0);
    do_read(11'h010, g);  check("R1 R2 strobe write read", g, 8'h3C);
    do_write(11'h7FF, 8'hA5, 1'b0);
    do_read(11'h7FF, g);  check("R1 R2 top address", g, 8'hA5);
    do_read(11'h010, g);  check("R1 neighbour intact", g, 8'h3C);
  endtask

  task automatic t_select_write();
    logic [DW-1:0] g;
    do_write(11'h020, 8'h5A, 1'b1);
    do_read(11'h020, g);  check("R3 select-ended write", g, 8'h5A);
  endtask

  task automatic t_last_data();
    logic [DW-1:0] g;
    @(negedge clk);
    addr = 11'h021; tb_val = 8'h11; tb_en = 1'b1; sel_n = 1'b0;
    idle(1); wr_n = 1'b0;
    idle(3); tb_val = 8'h66;
    idle(2); wr_n = 1'b1;
    idle(2); sel_n = 1'b1; tb_en = 1'b0;
    idle(2);
    do_read(11'h021, g);  check("R4 last bus value stored", g, 8'h66);
  endtask

  task automatic t_enable_gating();
    @(negedge clk);
    addr = 11'h010; wr_n = 1'b1; sel_n = 1'b0; rd_en_n = 1'b1;
    idle(3); check("R9 output enable high floats", dq, 8'hFF);
    sel_n = 1'b1; rd_en_n = 1'b0;
    idle(3); check("R9 select high floats", dq, 8'hFF);
    rd_en_n = 1'b1;
    idle(2);
  endtask

  task automatic t_write_override();
    logic [DW-1:0] g;
    @(negedge clk);
    addr = 11'h030; sel_n = 1'b0; rd_en_n = 1'b0; wr_n = 1'b0;
    idle(4); check("R5 write strobe suppresses drive", dq, 8'hFF);
    wr_n = 1'b1; idle(1); sel_n = 1'b1; rd_en_n = 1'b1;
    idle(2);
    do_read(11'h030, g);  check("R5 floating bus byte stored", g, 8'hFF);
  endtask

  task automatic t_power();
    logic [DW-1:0] g;
    @(negedge clk); pwr_good = 1'b0;
    addr = 11'h010; sel_n = 1'b0; rd_en_n = 1'b0;
    idle(3); check("R6 bus floats with power bad", dq, 8'hFF);
    sel_n = 1'b1; rd_en_n = 1'b1;
    idle(1);
    do_write(11'h010, 8'h99, 1'b0);
    do_write(11'h020, 8'h98, 1'b1);
    @(negedge clk); pwr_good = 1'b1;
    idle(2);
    do_read(11'h010, g);  check("R6 R7 strobe write blocked", g, 8'h3C);
    do_read(11'h020, g);  check("R6 R7 select write blocked", g, 8'h5A);
  endtask

  task automatic t_power_abort();
    logic [DW-1:0] g;
    @(negedge clk);
    addr = 11'h010; tb_val = 8'h77; tb_en = 1'b1; sel_n = 1'b0;
    idle(1); wr_n = 1'b0;
    idle(3); pwr_good = 1'b0;
    idle(2); wr_n = 1'b1; sel_n = 1'b1; tb_en = 1'b0;
    idle(2); pwr_good = 1'b1;
    idle(2);
    do_read(11'h010, g);  check("R10 aborted write discarded", g, 8'h3C);
  endtask

  task automatic t_reset_persist();
    logic [DW-1:0] g;
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    idle(4);
    check("R9 error clear after reset", {7'd0, addr_err}, 8'h00);
    do_read(11'h7FF, g);  check("R7 contents survive reset", g, 8'hA5);
  endtask

  task automatic t_addr_move();
    logic [DW-1:0] g;
    @(negedge clk);
    addr = 11'h040; tb_val = 8'hC3; tb_en = 1'b1; sel_n = 1'b0;
    idle(1); wr_n = 1'b0;
    idle(2); addr = 11'h041;
    idle(2); wr_n = 1'b1;
    idle(2); sel_n = 1'b1; tb_en = 1'b0;
    idle(2);
    check("R8 error raised", {7'd0, addr_err}, 8'h01);
    do_read(11'h040, g);  check("R8 byte at opening address", g, 8'hC3);
    check("R8 error held after read", {7'd0, addr_err}, 8'h01);
    do_write(11'h050, 8'h0F, 1'b0);
    check("R8 error cleared by next write", {7'd0, addr_err}, 8'h00);
    do_read(11'h050, g);  check("R2 clean write after error", g, 8'h0F);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    pwr_good = 1'b1;
    t_reset();
    t_basic();
    t_select_write();
    t_last_data();
    t_enable_gating();
    t_write_override();
    t_power();
    t_power_abort();
    t_reset_persist();
    t_addr_move();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule